// File: doc/BRIEF.md
# Upright Foreground Region Classifier

This block takes a binary foreground mask that has already been cleaned, one pixel per valid cycle in raster order. A frame starts with a start-of-frame marker. While the frame streams in, the block keeps a foreground count for every column. It also records the first and last rows that hold any foreground pixel. After the last pixel of the frame it walks the column counts from left to right. Columns whose count is under a programmable floor are treated as empty, so that two bodies joined by thin foreground can be told apart. Each remaining run of non-empty columns becomes one candidate region.

For every region the block reports a descriptor: start column, width, shared height, area, and a flag saying whether the region looks like one upright walking person. The flag is set only when the area exceeds a programmable threshold, the region is taller than it is wide, and its height-to-width ratio falls inside a programmable window. The window is tested by cross-multiplication, so no divider is needed. A done pulse closes the frame's output. Median filtering, morphology and tracking happen elsewhere.

Top module: `fg_region_classifier`

## Requirements
- R1: After reset, desc_valid, frame_done and desc_overflow are all low.
- R2: A region is a maximal run of adjacent columns whose foreground count is nonzero and not below col_thr. Columns under col_thr count as empty and split regions. desc_start is the first column of the run and desc_width is the number of columns in it.
- R3: desc_area is the sum of the column counts over the columns of the region.
- R4: desc_height is the last row index containing any foreground pixel, minus the first such row index, plus one. It is taken over the whole frame and is the same for every region of that frame.
- R5: desc_human is 1 only when all four tests pass: desc_area > area_thr, desc_height > desc_width, desc_height*16 >= desc_width*ratio_min, and desc_height*16 <= desc_width*ratio_max. The ratio inputs carry 4 fractional bits.
- R6: Descriptors appear as single-cycle desc_valid pulses in strictly increasing column order, with at least one empty column between consecutive regions.
- R7: At most MAXR (default 8) descriptors are emitted per frame. If more regions exist, desc_overflow goes high and stays high until the next start of frame.
- R8: frame_done is a one-cycle pulse, issued after the final descriptor of the frame.
- R9: A pixel with pix_sof high clears all counts and starts a frame. Cycles with pix_valid low, and pixels arriving while no frame is open, have no effect on the results.
- R10: A region that reaches the rightmost column is closed and reported at the end of the scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_valid | input | 1 | Pixel strobe |
| pix_sof | input | 1 | Marks the first pixel of a frame |
| pix_fg | input | 1 | Foreground bit of the pixel |
| col_thr | input | $clog2(ROWS+1) | Column count floor; columns under it count as empty |
| area_thr | input | $clog2(COLS*ROWS+1) | Area must exceed this value for a human |
| ratio_min | input | RATW | Lower height/width bound, 4 fractional bits |
| ratio_max | input | RATW | Upper height/width bound, 4 fractional bits |
| desc_valid | output | 1 | Descriptor strobe |
| desc_start | output | $clog2(COLS) | First column of the region |
| desc_width | output | $clog2(COLS)+1 | Columns in the region |
| desc_height | output | $clog2(ROWS)+1 | Vertical foreground extent of the frame |
| desc_area | output | $clog2(COLS*ROWS+1) | Foreground pixels in the region |
| desc_human | output | 1 | Region classified as upright person |
| desc_overflow | output | 1 | More regions existed than could be reported |
| frame_done | output | 1 | End-of-output pulse |

## Verification
The scan is driven with several masks. Two separate tall bars check segmentation and area. Two bars joined by a one-pixel bridge are run first with a floor that cuts the bridge and then with one that keeps it. A single scene holds a squat blob and a tiny blob, which fail different human tests. Other cases cover a bar touching the right edge, ten thin stripes that exceed the descriptor limit, and a tight ratio window that rejects an otherwise valid person. Idle cycles carrying a set foreground bit, and stray pixels sent before a frame opens, show whether unqualified input leaks into the counts. Back-to-back frames show that counts and the overflow flag restart.

// File: rtl/fg_region_classifier.sv
module fg_region_classifier #(
  parameter int COLS = 128,
  parameter int ROWS = 128,
  parameter int MAXR = 8,
  parameter int FRAC = 4,
  parameter int RATW = 8,
  localparam int CW = $clog2(COLS),
  localparam int RW = $clog2(ROWS),
  localparam int PW = $clog2(ROWS + 1),
  localparam int AW = $clog2(COLS * ROWS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_valid,
  input  logic          pix_sof,
  input  logic          pix_fg,
  input  logic [PW-1:0] col_thr,
  input  logic [AW-1:0] area_thr,
  input  logic [RATW-1:0] ratio_min,
  input  logic [RATW-1:0] ratio_max,
  output logic          desc_valid,
  output logic [CW-1:0] desc_start,
  output logic [CW:0]   desc_width,
  output logic [RW:0]   desc_height,
  output logic [AW-1:0] desc_area,
  output logic          desc_human,
  output logic          desc_overflow,
  output logic          frame_done
);
  localparam int NW = $clog2(MAXR + 1);
  localparam int MW = RW + 1 + FRAC + CW + 1 + RATW;

  typedef enum logic [1:0] {S_IDLE, S_ACC, S_SCAN, S_DONE} state_t;
  state_t st;

  logic [PW-1:0] proj [COLS];
  logic [CW-1:0] col, rs;
  logic [RW-1:0] row, top, bot;
  logic          seen, in_run;
  logic [CW:0]   si;
  logic [AW-1:0] racc;
  logic [NW-1:0] nreg;

  wire take = pix_valid && (st == S_ACC || (st == S_IDLE && pix_sof));
  wire [CW-1:0] ccol = pix_sof ? '0 : col;
  wire [RW-1:0] crow = pix_sof ? '0 : row;
  wire col_end = (ccol == CW'(COLS - 1));
  wire last = col_end && (crow == RW'(ROWS - 1));

  wire scan_end = (si == (CW+1)'(COLS));
  wire [PW-1:0] raw = scan_end ? '0 : proj[si[CW-1:0]];
  wire [PW-1:0] kept = (raw < col_thr) ? '0 : raw;
  wire hit = |kept;
  wire close = in_run && !hit;

  wire [CW:0] run_w = si - {1'b0, rs};
  wire [RW:0] run_h = seen ? ({1'b0, bot} - {1'b0, top} + (RW+1)'(1)) : '0;
  wire [MW-1:0] h_sc = MW'(run_h) << FRAC;
  wire [MW-1:0] w_lo = MW'(run_w) * MW'(ratio_min);
  wire [MW-1:0] w_hi = MW'(run_w) * MW'(ratio_max);
  wire human = (racc > area_thr) && (MW'(run_h) > MW'(run_w)) &&
               (h_sc >= w_lo) && (h_sc <= w_hi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < COLS; c++) proj[c] <= '0;
    end else if (take) begin
      if (pix_sof)
        for (int c = 0; c < COLS; c++) proj[c] <= '0;
      if (pix_fg)
        proj[ccol] <= (pix_sof ? '0 : proj[ccol]) + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      col <= '0; row <= '0; top <= '0; bot <= '0; seen <= 1'b0;
      si <= '0; rs <= '0; in_run <= 1'b0; racc <= '0; nreg <= '0;
      desc_valid <= 1'b0; desc_start <= '0; desc_width <= '0;
      desc_height <= '0; desc_area <= '0; desc_human <= 1'b0;
      desc_overflow <= 1'b0; frame_done <= 1'b0;
    end else begin
      desc_valid <= 1'b0;
      frame_done <= 1'b0;
      case (st)
        S_IDLE, S_ACC: if (take) begin
          if (pix_sof) begin
            seen <= 1'b0;
            desc_overflow <= 1'b0;
            nreg <= '0;
            in_run <= 1'b0;
            racc <= '0;
          end
          if (pix_fg) begin
            if (!seen || pix_sof) top <= crow;
            bot <= crow;
            seen <= 1'b1;
          end
          col <= col_end ? '0 : ccol + CW'(1);
          row <= col_end ? crow + RW'(1) : crow;
          si <= '0;
          st <= last ? S_SCAN : S_ACC;
        end
        S_SCAN: begin
          if (hit) begin
            if (!in_run) begin
              rs <= si[CW-1:0];
              racc <= AW'(kept);
            end else begin
              racc <= racc + AW'(kept);
            end
            in_run <= 1'b1;
          end
          if (close) begin
            in_run <= 1'b0;
            if (nreg == NW'(MAXR)) begin
              desc_overflow <= 1'b1;
            end else begin
              desc_valid <= 1'b1;
              desc_start <= rs;
              desc_width <= run_w;
              desc_height <= run_h;
              desc_area <= racc;
              desc_human <= human;
              nreg <= nreg + NW'(1);
            end
          end
          if (scan_end) st <= S_DONE;
          else si <= si + (CW+1)'(1);
        end
        default: begin
          frame_done <= 1'b1;
          st <= S_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/region_chk.sv
module region_chk #(
  parameter int COLS = 128,
  parameter int ROWS = 128,
  parameter int MAXR = 8,
  localparam int CW = $clog2(COLS),
  localparam int RW = $clog2(ROWS),
  localparam int AW = $clog2(COLS * ROWS + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pix_valid,
  input logic          pix_sof,
  input logic [AW-1:0] area_thr,
  input logic          desc_valid,
  input logic [CW-1:0] desc_start,
  input logic [CW:0]   desc_width,
  input logic [RW:0]   desc_height,
  input logic [AW-1:0] desc_area,
  input logic          desc_human,
  input logic          desc_overflow,
  input logic          frame_done
);
  logic [CW+1:0] nxt_min;
  logic [31:0]   cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nxt_min <= '0;
      cnt <= '0;
    end else if (frame_done) begin
      nxt_min <= '0;
      cnt <= '0;
    end else if (desc_valid) begin
      nxt_min <= (CW+2)'(desc_start) + (CW+2)'(desc_width) + (CW+2)'(1);
      cnt <= cnt + 32'd1;
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  // R5
  human_upright_chk: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid && desc_human |-> desc_height > desc_width);

  // R5
  human_area_chk: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid && desc_human |-> desc_area > area_thr);

  // R2
  region_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |-> desc_width != '0 && (32'(desc_start) + 32'(desc_width)) <= COLS);

  // R6
  order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |-> (CW+2)'(desc_start) >= nxt_min);

  // R7
  limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |-> cnt < MAXR);

  // R7
  overflow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(desc_overflow) |-> $past(pix_valid && pix_sof));
endmodule

bind fg_region_classifier region_chk #(.COLS(COLS), .ROWS(ROWS), .MAXR(MAXR)) u_region_chk (
  .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_sof(pix_sof),
  .area_thr(area_thr), .desc_valid(desc_valid), .desc_start(desc_start),
  .desc_width(desc_width), .desc_height(desc_height), .desc_area(desc_area),
  .desc_human(desc_human), .desc_overflow(desc_overflow), .frame_done(frame_done)
);

// File: tb/tb_fg_region_classifier.sv
module tb_fg_region_classifier;
  localparam int COLS = 20;
  localparam int ROWS = 8;
  localparam int MAXR = 8;
  localparam int CW = $clog2(COLS);
  localparam int RW = $clog2(ROWS);
  localparam int PW = $clog2(ROWS + 1);
  localparam int AW = $clog2(COLS * ROWS + 1);

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, pix_valid, pix_sof, pix_fg;
  logic [PW-1:0] col_thr;
  logic [AW-1:0] area_thr;
  logic [7:0] ratio_min, ratio_max;
  logic desc_valid, desc_human, desc_overflow, frame_done;
  logic [CW-1:0] desc_start;
  logic [CW:0] desc_width;
  logic [RW:0] desc_height;
  logic [AW-1:0] desc_area;

  fg_region_classifier #(.COLS(COLS), .ROWS(ROWS), .MAXR(MAXR)) dut (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_sof(pix_sof), .pix_fg(pix_fg),
    .col_thr(col_thr), .area_thr(area_thr), .ratio_min(ratio_min), .ratio_max(ratio_max),
    .desc_valid(desc_valid), .desc_start(desc_start), .desc_width(desc_width),
    .desc_height(desc_height), .desc_area(desc_area), .desc_human(desc_human),
    .desc_overflow(desc_overflow), .frame_done(frame_done));

  int checks = 0, errors = 0;
  bit img [ROWS][COLS];
  int g_n;
  int g_start [16], g_width [16], g_height [16], g_area [16];
  bit g_human [16];
  bit done_seen;

  always @(negedge clk) begin
    if (desc_valid) begin
      if (g_n < 16) begin
        g_start[g_n] = int'(desc_start); g_width[g_n] = int'(desc_width);
        g_height[g_n] = int'(desc_height); g_area[g_n] = int'(desc_area);
        g_human[g_n] = desc_human;
      end
      g_n++;
    end
    if (frame_done) done_seen = 1'b1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr();
    for (int r = 0; r < ROWS; r++) for (int c = 0; c < COLS; c++) img[r][c] = 1'b0;
  endtask

  task automatic rect(input int r0, input int r1, input int c0, input int c1);
    for (int r = r0; r <= r1; r++) for (int c = c0; c <= c1; c++) img[r][c] = 1'b1;
  endtask

  task automatic send_frame(input bit gaps);
    g_n = 0;
    done_seen = 1'b0;
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) begin
        @(negedge clk);
        pix_valid = 1'b1; pix_sof = (r == 0 && c == 0); pix_fg = img[r][c];
        if (gaps && (c % 3 == 1)) begin
          @(negedge clk);
          pix_valid = 1'b0; pix_sof = 1'b0; pix_fg = 1'b1;
        end
      end
    end
    @(negedge clk);
    pix_valid = 1'b0; pix_sof = 1'b0; pix_fg = 1'b0;
  endtask

  task automatic check_frame(input string tag);
    int pc [COLS];
    int top, bot, h, en, s, a, v, t, w, lim;
    bit inr;
    int e_start [16], e_width [16], e_area [16];
    bit e_human [16];
    top = -1; bot = -1; en = 0; s = 0; a = 0; inr = 1'b0;
    for (int c = 0; c < COLS; c++) pc[c] = 0;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        if (img[r][c]) begin
          pc[c]++;
          if (top < 0) top = r;
          bot = r;
        end
    h = (top < 0) ? 0 : bot - top + 1;
    for (int c = 0; c <= COLS; c++) begin
      v = (c < COLS && pc[c] >= int'(col_thr)) ? pc[c] : 0;
      if (v > 0) begin
        if (!inr) begin s = c; a = 0; inr = 1'b1; end
        a += v;
      end else if (inr) begin
        w = c - s;
        if (en < 16) begin
          e_start[en] = s; e_width[en] = w; e_area[en] = a;
          e_human[en] = (a > int'(area_thr)) && (h > w) &&
                        (h * 16 >= w * int'(ratio_min)) && (h * 16 <= w * int'(ratio_max));
        end
        en++;
        inr = 1'b0;
      end
    end
    t = 0;
    while (!done_seen && t < 2000) begin
      @(negedge clk); #1; t++;
    end
    chk(done_seen, {"R8 done seen ", tag}, int'(done_seen), 1);
    @(negedge clk); #1;
    chk(frame_done == 1'b0, {"R8 done single cycle ", tag}, int'(frame_done), 0);
    lim = (en > MAXR) ? MAXR : en;
    chk(g_n == lim, {"R2 R7 region count ", tag}, g_n, lim);
    chk(desc_overflow == (en > MAXR), {"R7 overflow ", tag}, int'(desc_overflow), int'(en > MAXR));
    for (int i = 0; i < lim && i < g_n; i++) begin
      chk(g_start[i] == e_start[i], {"R2 R6 start ", tag}, g_start[i], e_start[i]);
      chk(g_width[i] == e_width[i], {"R2 R10 width ", tag}, g_width[i], e_width[i]);
      chk(g_area[i] == e_area[i], {"R3 area ", tag}, g_area[i], e_area[i]);
      chk(g_height[i] == h, {"R4 height ", tag}, g_height[i], h);
      chk(g_human[i] == e_human[i], {"R5 human ", tag}, int'(g_human[i]), int'(e_human[i]));
    end
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    chk(desc_valid == 1'b0, "R1 desc_valid", int'(desc_valid), 0);
    chk(frame_done == 1'b0, "R1 frame_done", int'(frame_done), 0);
    chk(desc_overflow == 1'b0, "R1 overflow", int'(desc_overflow), 0);
  endtask

  task automatic t_two_people();
    clr(); rect(1, 6, 2, 3); rect(2, 7, 8, 10);
    send_frame(1'b0); check_frame("two people");
    chk(g_n == 2 && g_human[0] && g_human[1], "R5 both human", g_n, 2);
  endtask

  task automatic t_bridge();
    clr(); rect(0, 6, 3, 4); rect(0, 6, 8, 9); rect(3, 3, 5, 7);
    col_thr = 2;
    send_frame(1'b0); check_frame("bridge cut");
    chk(g_n == 2, "R2 bridge separates", g_n, 2);
    col_thr = 1;
    send_frame(1'b0); check_frame("bridge kept");
    chk(g_n == 1, "R2 bridge joins", g_n, 1);
    col_thr = 2;
  endtask

  task automatic t_shapes();
    clr(); rect(2, 5, 1, 8); rect(6, 7, 14, 14);
    send_frame(1'b0); check_frame("wide and tiny");
    chk(g_n == 2 && !g_human[0] && !g_human[1], "R5 neither human", g_n, 2);
  endtask

  task automatic t_right_edge();
    clr(); rect(1, 7, COLS - 2, COLS - 1);
    send_frame(1'b0); check_frame("right edge");
    chk(g_n == 1 && g_start[0] == COLS - 2, "R10 edge region", g_start[0], COLS - 2);
  endtask

  task automatic t_overflow();
    clr();
    for (int c = 0; c < COLS; c += 2) rect(0, 3, c, c);
    send_frame(1'b0); check_frame("ten stripes");
    clr(); rect(1, 6, 5, 6);
    send_frame(1'b0); check_frame("after overflow");
    chk(desc_overflow == 1'b0, "R7 overflow cleared by new frame", int'(desc_overflow), 0);
  endtask

  task automatic t_ignored();
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); pix_valid = 1'b1; pix_sof = 1'b0; pix_fg = 1'b1;
    end
    @(negedge clk); pix_valid = 1'b0; pix_fg = 1'b0; #1;
    chk(desc_valid == 1'b0 && frame_done == 1'b0, "R9 stray pixels produce nothing",
        int'(desc_valid | frame_done), 0);
    clr(); rect(2, 6, 12, 13);
    send_frame(1'b1); check_frame("gapped frame");
  endtask

  task automatic t_ratio();
    clr(); rect(0, 7, 4, 5);
    ratio_max = 8'd40;
    send_frame(1'b0); check_frame("tight ratio window");
    chk(g_n == 1 && !g_human[0], "R5 ratio above max rejected", int'(g_human[0]), 0);
    ratio_max = 8'd80;
  endtask

  initial begin
    #(8 * 150000);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pix_valid = 1'b0; pix_sof = 1'b0; pix_fg = 1'b0;
    col_thr = 2; area_thr = 5; ratio_min = 8'd24; ratio_max = 8'd80;
    g_n = 0; done_seen = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_two_people();
    t_bridge();
    t_shapes();
    t_right_edge();
    t_overflow();
    t_ignored();
    t_ratio();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule